// File: doc/BRIEF.md
# I2C Controller Status Flags

This block keeps the status byte of an I2C controller that can act as either bus master or bus slave. The bus engine around it handles shifting, line driving and start/stop detection. It reports each result to this block as a single-cycle pulse: byte finished (with its direction), own address matched, start generated, address byte sent, acknowledge missing, stop detected, arbitration lost, bus error, and start or stop seen on the bus. The block latches these pulses into sticky flags and packs them into one read-only byte.

The CPU side of the block sees only strobes that mark which register is being accessed. The block has one strobe each for a status-byte read, a second-status read, a data-register access (read or write), an access to any other register, and a write of the START control bit. Some flags clear only after a particular order of accesses, so a one-bit marker remembers that the status byte was read. While a byte-finished or address-matched flag is pending, the block asks the bus engine to stretch SCL low, and it can raise an interrupt. When the enable input is low, every flag is forced to zero except bus-busy, which simply keeps its value.

Top module: `i2c_stat_top`

## Requirements
- R1: After reset the status byte is 00h, and `irq` and `holdScl` are 0. Bit 6 of the status byte always reads 0.
- R2: Status byte layout: bit 7 event summary, bit 5 transmit/receive, bit 4 bus busy, bit 3 byte finished, bit 2 address matched, bit 1 master (1) or slave (0), bit 0 start generated.
- R3: The event summary bit is 1 whenever any of these is pending: byte finished, address matched while `ackEnable` is 1, start generated, address byte sent, acknowledge failure, stop detected, arbitration lost, or bus error.
- R4: A `evByteDone` pulse sets byte finished. In the same cycle, transmit/receive takes the value of `evByteTx` (1 for transmitted, 0 for received).
- R5: Byte finished, start generated and address-sent clear on a data-register access only when the most recent earlier access was a status-byte read. Any other access in between cancels that status read. Transmit/receive clears together with byte finished.
- R6: Address matched is set by `evAddrMatch` and cleared by a status-byte read. If both happen in the same cycle, the set wins.
- R7: `holdScl` is 1 exactly while byte finished or address matched is 1. `irq` is 1 when `intEnable` is 1 and one of those two flags is 1.
- R8: Acknowledge failure, arbitration lost, bus error and stop detected stay latched until a second-status read clears them.
- R9: Bus busy is set by a bus start and cleared by a bus stop or a bus error. It does not change at all while `enable` is 0.
- R10: The master flag is set by a START write. It is cleared by stop detection or arbitration loss. Transmit/receive is also cleared by stop detection and by arbitration loss.
- R11: While `enable` is 0, all flags except bus busy read 0 one cycle later, and event pulses and access strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Interface enable |
| intEnable | input | 1 | Interrupt enable |
| ackEnable | input | 1 | Acknowledge enable (qualifies address match in summary) |
| evByteDone | input | 1 | Byte transfer finished pulse |
| evByteTx | input | 1 | Direction of finished byte, 1 = transmitted |
| evAddrMatch | input | 1 | Own address or general call matched pulse |
| evStartGen | input | 1 | Start generated as master pulse |
| evAddrSent | input | 1 | Address byte sent as master pulse |
| evAckFail | input | 1 | No acknowledge received pulse |
| evStopDet | input | 1 | Stop detected in slave mode pulse |
| evArbLost | input | 1 | Arbitration lost pulse |
| evBusErr | input | 1 | Misplaced start/stop pulse |
| evBusStart | input | 1 | Start condition seen on bus |
| evBusStop | input | 1 | Stop condition seen on bus |
| cpuStatusRd | input | 1 | Status byte read strobe |
| cpuStatus2Rd | input | 1 | Second status register read strobe |
| cpuDataAcc | input | 1 | Data register read or write strobe |
| cpuOtherAcc | input | 1 | Access to any other register |
| cpuStartWr | input | 1 | Write of the START control bit |
| statusByte | output | 8 | Packed status flags |
| irq | output | 1 | Interrupt request |
| holdScl | output | 1 | Request to hold SCL low |

## Verification
The in-module assertions watch, on every cycle, that flags read zero after a disabled cycle, that bus-busy holds while disabled, that byte finished stays set until its clearing strobe, that arbitration loss drops the master flag, and that a lone status read arms the marker. Only the bench scenarios can show the access-order rule: a status read followed by a data access clears, while an intervening access cancels it. The scenarios also cover the summary bit's dependence on `ackEnable`, the set-over-clear priority, and the clearing of the error causes by the second-status read.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int STAT_W = 8;
  localparam int BIT_EVF = 7;
  localparam int BIT_TRA = 5;
  localparam int BIT_BUSY = 4;
  localparam int BIT_BTF = 3;
  localparam int BIT_ADR = 2;
  localparam int BIT_MST = 1;
  localparam int BIT_SB = 0;

  typedef struct packed {
    logic clrSeq;
    logic clrAddr;
    logic clrErr;
    logic setMaster;
  } statCtrl_t;
endpackage

// File: rtl/i2c_stat_ctrl.sv
module i2c_stat_ctrl
  import i2c_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      cpuStatusRd,
  input  logic      cpuStatus2Rd,
  input  logic      cpuDataAcc,
  input  logic      cpuOtherAcc,
  input  logic      cpuStartWr,
  output statCtrl_t strobes
);
  logic statusSeen;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) statusSeen <= 1'b0;
    else if (cpuStatusRd) statusSeen <= 1'b1;
    else if (cpuDataAcc || cpuOtherAcc || cpuStatus2Rd) statusSeen <= 1'b0;
  end

  always_comb begin
    strobes.clrSeq    = enable && cpuDataAcc && statusSeen;
    strobes.clrAddr   = enable && cpuStatusRd;
    strobes.clrErr    = enable && cpuStatus2Rd;
    strobes.setMaster = enable && cpuStartWr;
  end

  // R5
  marker_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && cpuStatusRd && !cpuDataAcc && !cpuOtherAcc && !cpuStatus2Rd) |=> statusSeen);
endmodule

// File: rtl/i2c_stat_dp.sv
module i2c_stat_dp
  import i2c_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              intEnable,
  input  logic              ackEnable,
  input  logic              evByteDone,
  input  logic              evByteTx,
  input  logic              evAddrMatch,
  input  logic              evStartGen,
  input  logic              evAddrSent,
  input  logic              evAckFail,
  input  logic              evStopDet,
  input  logic              evArbLost,
  input  logic              evBusErr,
  input  logic              evBusStart,
  input  logic              evBusStop,
  input  statCtrl_t         strobes,
  output logic [STAT_W-1:0] statusByte,
  output logic              irq,
  output logic              holdScl
);
  logic btfFlag, traFlag, adrFlag, sbFlag, sentFlag;
  logic afFlag, arloFlag, berrFlag, stopFlag, mstFlag, busyFlag;
  logic evfSum;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      btfFlag <= 1'b0; traFlag <= 1'b0; adrFlag <= 1'b0; sbFlag <= 1'b0;
      sentFlag <= 1'b0; afFlag <= 1'b0; arloFlag <= 1'b0; berrFlag <= 1'b0;
      stopFlag <= 1'b0; mstFlag <= 1'b0;
    end else if (!enable) begin
      btfFlag <= 1'b0; traFlag <= 1'b0; adrFlag <= 1'b0; sbFlag <= 1'b0;
      sentFlag <= 1'b0; afFlag <= 1'b0; arloFlag <= 1'b0; berrFlag <= 1'b0;
      stopFlag <= 1'b0; mstFlag <= 1'b0;
    end else begin
      if (evByteDone) btfFlag <= 1'b1;
      else if (strobes.clrSeq) btfFlag <= 1'b0;

      if (evByteDone) traFlag <= evByteTx;
      else if (strobes.clrSeq || evStopDet || evArbLost) traFlag <= 1'b0;

      if (evAddrMatch) adrFlag <= 1'b1;
      else if (strobes.clrAddr) adrFlag <= 1'b0;

      if (evStartGen) sbFlag <= 1'b1;
      else if (strobes.clrSeq) sbFlag <= 1'b0;

      if (evAddrSent) sentFlag <= 1'b1;
      else if (strobes.clrSeq) sentFlag <= 1'b0;

      if (evAckFail) afFlag <= 1'b1;
      else if (strobes.clrErr) afFlag <= 1'b0;

      if (evArbLost) arloFlag <= 1'b1;
      else if (strobes.clrErr) arloFlag <= 1'b0;

      if (evBusErr) berrFlag <= 1'b1;
      else if (strobes.clrErr) berrFlag <= 1'b0;

      if (evStopDet) stopFlag <= 1'b1;
      else if (strobes.clrErr) stopFlag <= 1'b0;

      if (evStopDet || evArbLost) mstFlag <= 1'b0;
      else if (strobes.setMaster) mstFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyFlag <= 1'b0;
    else if (enable) begin
      if (evBusStart) busyFlag <= 1'b1;
      else if (evBusStop || evBusErr) busyFlag <= 1'b0;
    end
  end

  always_comb begin
    evfSum = btfFlag || (adrFlag && ackEnable) || sbFlag || sentFlag ||
             afFlag || arloFlag || berrFlag || stopFlag;
    statusByte = '0;
    statusByte[BIT_EVF]  = evfSum;
    statusByte[BIT_TRA]  = traFlag;
    statusByte[BIT_BUSY] = busyFlag;
    statusByte[BIT_BTF]  = btfFlag;
    statusByte[BIT_ADR]  = adrFlag;
    statusByte[BIT_MST]  = mstFlag;
    statusByte[BIT_SB]   = sbFlag;
    holdScl = btfFlag || adrFlag;
    irq     = intEnable && (btfFlag || adrFlag);
  end

  // R11
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ((statusByte & 8'hEF) == 8'h00));
  // R9
  busy_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(busyFlag));
  // R5
  btf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (btfFlag && enable && !strobes.clrSeq) |=> btfFlag);
  // R10
  arb_drops_master_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && evArbLost) |=> !mstFlag);
endmodule

// File: rtl/i2c_stat_top.sv
module i2c_stat_top
  import i2c_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       intEnable,
  input  logic       ackEnable,
  input  logic       evByteDone,
  input  logic       evByteTx,
  input  logic       evAddrMatch,
  input  logic       evStartGen,
  input  logic       evAddrSent,
  input  logic       evAckFail,
  input  logic       evStopDet,
  input  logic       evArbLost,
  input  logic       evBusErr,
  input  logic       evBusStart,
  input  logic       evBusStop,
  input  logic       cpuStatusRd,
  input  logic       cpuStatus2Rd,
  input  logic       cpuDataAcc,
  input  logic       cpuOtherAcc,
  input  logic       cpuStartWr,
  output logic [7:0] statusByte,
  output logic       irq,
  output logic       holdScl
);
  statCtrl_t strobes;

  i2c_stat_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cpuStatusRd(cpuStatusRd), .cpuStatus2Rd(cpuStatus2Rd),
    .cpuDataAcc(cpuDataAcc), .cpuOtherAcc(cpuOtherAcc),
    .cpuStartWr(cpuStartWr), .strobes(strobes)
  );

  i2c_stat_dp uDp (
    .clk(clk), .rstN(rstN), .enable(enable), .intEnable(intEnable),
    .ackEnable(ackEnable), .evByteDone(evByteDone), .evByteTx(evByteTx),
    .evAddrMatch(evAddrMatch), .evStartGen(evStartGen), .evAddrSent(evAddrSent),
    .evAckFail(evAckFail), .evStopDet(evStopDet), .evArbLost(evArbLost),
    .evBusErr(evBusErr), .evBusStart(evBusStart), .evBusStop(evBusStop),
    .strobes(strobes), .statusByte(statusByte), .irq(irq), .holdScl(holdScl)
  );

  // R7
  hold_follows_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> holdScl);
endmodule

// File: tb/sim_i2c_stat_top.sv
module sim_i2c_stat_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, intEnable = 1'b0, ackEnable = 1'b0;
  logic [15:0] ev = '0;
  logic [7:0] statusByte;
  logic irq, holdScl;

  localparam int B_DONE = 0, B_TX = 1, B_AM = 2, B_SG = 3, B_AF = 4, B_SD = 5,
                 B_AL = 6, B_BE = 7, B_BS = 8, B_BP = 9, B_AS = 10, B_SR = 11,
                 B_S2 = 12, B_DA = 13, B_OA = 14, B_SW = 15;

  always #4 clk = ~clk;

  i2c_stat_top u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .intEnable(intEnable),
    .ackEnable(ackEnable), .evByteDone(ev[B_DONE]), .evByteTx(ev[B_TX]),
    .evAddrMatch(ev[B_AM]), .evStartGen(ev[B_SG]), .evAddrSent(ev[B_AS]),
    .evAckFail(ev[B_AF]), .evStopDet(ev[B_SD]), .evArbLost(ev[B_AL]),
    .evBusErr(ev[B_BE]), .evBusStart(ev[B_BS]), .evBusStop(ev[B_BP]),
    .cpuStatusRd(ev[B_SR]), .cpuStatus2Rd(ev[B_S2]), .cpuDataAcc(ev[B_DA]),
    .cpuOtherAcc(ev[B_OA]), .cpuStartWr(ev[B_SW]),
    .statusByte(statusByte), .irq(irq), .holdScl(holdScl)
  );

  int checks = 0, errors = 0;
  string tagQ[$];
  logic [9:0] expQ[$];
  bit armed = 1'b0;
  bit done = 1'b0;

  function automatic logic [15:0] bv(int b);
    return 16'(1) << b;
  endfunction

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic cyc(string tag, logic [15:0] v, logic [7:0] st, logic i, logic h);
    @(negedge clk);
    ev = v;
    tagQ.push_back(tag);
    expQ.push_back({st, i, h});
  endtask

  // monitor: compare after the capturing edge, before inputs change
  always @(posedge clk) begin
    #1;
    if (armed && expQ.size() > 0) begin
      logic [9:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if ({statusByte, irq, holdScl} !== e) begin
        errors++;
        $display("FAIL %s: got st=%h irq=%b hold=%b expected st=%h irq=%b hold=%b",
                 t, statusByte, irq, holdScl, e[9:2], e[1], e[0]);
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({statusByte, irq, holdScl} !== 10'h000) begin
      errors++;
      $display("FAIL R1 reset: got %h expected 000", {statusByte, irq, holdScl});
    end
    rstN = 1'b1;
    enable = 1'b1; intEnable = 1'b1; ackEnable = 1'b1;
    armed = 1'b1;
    cyc("R9 bus start sets busy", bv(B_BS), 8'h10, 0, 0);
    cyc("R10 START write sets master", bv(B_SW), 8'h12, 0, 0);
    cyc("R2 start generated bit0", bv(B_SG), 8'h93, 0, 0);
    cyc("R5 status read arms", bv(B_SR), 8'h93, 0, 0);
    cyc("R5 data access clears start", bv(B_DA), 8'h12, 0, 0);
    cyc("R3 address sent in summary", bv(B_AS), 8'h92, 0, 0);
    cyc("R4 tx byte done", bv(B_DONE) | bv(B_TX), 8'hBA, 1, 1);
    cyc("R5 status read", bv(B_SR), 8'hBA, 1, 1);
    cyc("R5 other access cancels", bv(B_OA), 8'hBA, 1, 1);
    cyc("R5 data access without status read", bv(B_DA), 8'hBA, 1, 1);
    cyc("R5 status read again", bv(B_SR), 8'hBA, 1, 1);
    cyc("R5 data access clears btf tra", bv(B_DA), 8'h12, 0, 0);
    cyc("R8 ack failure latched", bv(B_AF), 8'h92, 0, 0);
    cyc("R8 second status read clears", bv(B_S2), 8'h12, 0, 0);
    cyc("R10 arbitration loss clears master", bv(B_AL), 8'h90, 0, 0);
    cyc("R8 clear arbitration", bv(B_S2), 8'h10, 0, 0);
    cyc("R6 address match", bv(B_AM), 8'h94, 1, 1);
    @(negedge clk); ackEnable = 1'b0;
    tagQ.push_back("R3 summary needs ackEnable"); expQ.push_back({8'h14, 1'b1, 1'b1});
    ev = '0;
    @(negedge clk); ackEnable = 1'b1; ev = bv(B_SR);
    tagQ.push_back("R6 status read clears match"); expQ.push_back({8'h10, 1'b0, 1'b0});
    @(negedge clk); intEnable = 1'b0; ev = bv(B_DONE);
    tagQ.push_back("R7 no irq when disabled int, rx byte"); expQ.push_back({8'h98, 1'b0, 1'b1});
    cyc("R10 stop detect with bus stop", bv(B_SD) | bv(B_BP), 8'h88, 0, 1);
    cyc("R8 stop cause cleared, btf remains", bv(B_S2), 8'h88, 0, 1);
    @(negedge clk); enable = 1'b0; ev = '0;
    tagQ.push_back("R11 disable forces flags"); expQ.push_back({8'h00, 1'b0, 1'b0});
    cyc("R9 busy frozen while disabled", bv(B_BS) | bv(B_AM), 8'h00, 0, 0);
    @(negedge clk); enable = 1'b1; intEnable = 1'b1; ev = bv(B_BS);
    tagQ.push_back("R9 busy set when enabled"); expQ.push_back({8'h10, 1'b0, 1'b0});
    cyc("R9 bus error clears busy", bv(B_BE), 8'h80, 0, 0);
    cyc("R8 clear bus error", bv(B_S2), 8'h00, 0, 0);
    cyc("R9 bus start", bv(B_BS), 8'h10, 0, 0);
    @(negedge clk); enable = 1'b0; ev = bv(B_BP);
    tagQ.push_back("R11 stop ignored while disabled"); expQ.push_back({8'h10, 1'b0, 1'b0});
    @(negedge clk); enable = 1'b1; ev = bv(B_SR) | bv(B_AM);
    tagQ.push_back("R6 set wins over clear"); expQ.push_back({8'h94, 1'b1, 1'b1});
    cyc("R6 status read clears", bv(B_SR), 8'h10, 0, 0);
    cyc("R1 bit6 idle", '0, 8'h10, 0, 0);
    @(negedge clk); ev = '0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule